// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block sits next to a UART receiver/transmitter pair and works out the bit period of a host that starts sending before any rate has been agreed. A strap pin sampled during reset selects whether detection runs at all. If it does not, the block keeps a fixed default divisor and stays inert. Once armed, the block waits for a falling start-bit edge on the serial input. It counts system clocks until the first rising edge and turns that count into a divisor in units of 16x oversampling.

Two training patterns are accepted. One is the single character 0x41. The other is the four-byte command 0x01, 0x03, 0x0C, 0x00. The first byte of either pattern sets the divisor. The divisor is then used to decode the rest of that byte and any bytes that follow. A recognised pattern locks the divisor and publishes it with a one-cycle strobe. The block then plays out a fixed acknowledgement through a byte-wide valid/ready transmit port. Anything that does not match is dropped silently, and the detector goes back to waiting for a new start edge.

Top module: `autobaud_detect`

## Requirements
- R1: The strap input is sampled while `rst` is high. If the last value sampled is 1, the block never locks or transmits, and `div_out` stays at `DEFAULT_DIV` (14) whatever arrives on `rx`. Only the value during reset counts.
- R2: In detection mode, the low time of the first start bit is counted in clocks, from the falling edge to the next rising edge of `rx`. This count is the measured period P.
- R3: Training with byte 0x41 (LSB first, one start bit, one stop bit) produces the transmit bytes 0x41, 0x30, 0x34, 0x31 in that order.
- R4: Training with bytes 0x01, 0x03, 0x0C, 0x00 produces the transmit bytes 0x04, 0x0E, 0x04, 0x01, 0x03, 0x0C, 0x00, 0x34, 0x31 in that order.
- R5: On success, `div_valid` pulses for exactly one cycle. In that cycle `locked` rises, and `div_out` carries the new divisor from then on. `locked` stays high until reset. No byte is offered before the lock.
- R6: The divisor equals floor((P+8)/16), which is P/16 rounded to nearest. A P of 16 gives 1, and the divisor is never below 1.
- R7: A P below 16 clocks is discarded. The block does not lock and keeps waiting for the next falling edge.
- R8: Any of the following abandons the attempt without locking: a first byte other than 0x41 or 0x01, a later command byte that differs from the expected one, or a low stop bit. A new training attempt is accepted after that.
- R9: `tx_data` and `tx_valid` hold steady while `tx_valid` is high and `tx_ready` is low. Each byte is accepted exactly once, with no gap or repeat in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_strap_n | input | 1 | Active-low detection strap, sampled during reset |
| rx | input | 1 | Serial input line, idle high |
| div_out | output | DIV_W | Oversampling divisor (default until locked) |
| div_valid | output | 1 | One-cycle strobe when the divisor locks |
| locked | output | 1 | Sticky flag: training succeeded |
| tx_data | output | 8 | Acknowledgement byte |
| tx_valid | output | 1 | Acknowledgement byte is offered |
| tx_ready | input | 1 | Consumer accepts the offered byte |

## Verification
The assertions check the following on every cycle: `locked` never falls, the strobe coincides with the rise of `locked`, the divisor is at least 1 once locked, and an unarmed block never locks. They also check that no byte is offered before the lock and that a stalled byte holds its value. The bench scenarios are needed for the rest: divisor rounding at several bit periods, the exact order of both acknowledgement sequences under a back-pressured port, and rejection of short pulses, foreign first bytes and a corrupted final command byte.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  typedef enum logic [2:0] {
    CT_BOOT, CT_OFF, CT_FIRST, CT_MORE, CT_RESP, CT_DONE
  } ctl_e;

  typedef enum logic [1:0] {
    FR_IDLE, FR_MEAS, FR_START, FR_BITS
  } fr_e;

  localparam logic [7:0] TRAIN_CHAR = 8'h41;

  // expected bytes of the four-byte training command
  function automatic logic [7:0] cmd_byte(input logic [1:0] i);
    case (i)
      2'd0:    cmd_byte = 8'h01;
      2'd1:    cmd_byte = 8'h03;
      2'd2:    cmd_byte = 8'h0C;
      default: cmd_byte = 8'h00;
    endcase
  endfunction

  // index of last acknowledgement byte for each training kind
  function automatic logic [3:0] reply_last(input logic sel_cmd);
    reply_last = sel_cmd ? 4'd8 : 4'd3;
  endfunction

  function automatic logic [7:0] reply_byte(input logic sel_cmd, input logic [3:0] i);
    if (!sel_cmd) begin
      case (i)
        4'd0:    reply_byte = 8'h41;
        4'd1:    reply_byte = 8'h30;
        4'd2:    reply_byte = 8'h34;
        default: reply_byte = 8'h31;
      endcase
    end else begin
      case (i)
        4'd0:    reply_byte = 8'h04;
        4'd1:    reply_byte = 8'h0E;
        4'd2:    reply_byte = 8'h04;
        4'd3:    reply_byte = 8'h01;
        4'd4:    reply_byte = 8'h03;
        4'd5:    reply_byte = 8'h0C;
        4'd6:    reply_byte = 8'h00;
        4'd7:    reply_byte = 8'h34;
        default: reply_byte = 8'h31;
      endcase
    end
  endfunction

endpackage

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/autobaud_frame.sv
module autobaud_frame
  import autobaud_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             measure,
  input  logic             fall,
  input  logic             rx_s,
  output logic [DIV_W-1:0] div_q,
  output logic             byte_vld,
  output logic [7:0]       byte_val,
  output logic             err
);
  localparam int CNT_W = DIV_W + 4;
  localparam int TMR_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'((1 << CNT_W) - 9);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(16);

  fr_e              st;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic [3:0]       bitn;
  logic [7:0]       shreg;
  logic [DIV_W-1:0] meas_div;
  logic [TMR_W-1:0] bit_t, half_t, first_t;

  assign meas_div = DIV_W'((cnt + CNT_W'(8)) >> 4);
  assign bit_t    = TMR_W'({div_q, 4'b0000});
  assign half_t   = TMR_W'({div_q, 3'b000});
  assign first_t  = TMR_W'({meas_div, 4'b0000}) + TMR_W'({meas_div, 3'b000});
  assign byte_val = shreg;

  always_ff @(posedge clk) begin
    byte_vld <= 1'b0;
    err      <= 1'b0;
    if (rst) begin
      st    <= FR_IDLE;
      cnt   <= '0;
      tmr   <= '0;
      bitn  <= '0;
      shreg <= '0;
      div_q <= DIV_W'(1);
    end else if (!en) begin
      st <= FR_IDLE;
    end else begin
      case (st)
        FR_IDLE: if (fall) begin
          if (measure) begin
            st  <= FR_MEAS;
            cnt <= CNT_W'(1);
          end else begin
            st  <= FR_START;
            tmr <= half_t - TMR_W'(1);
          end
        end
        FR_MEAS: begin
          if (rx_s) begin
            if (cnt < MIN_CNT) begin
              err <= 1'b1;
              st  <= FR_IDLE;
            end else begin
              div_q <= meas_div;
              tmr   <= first_t - TMR_W'(1);
              bitn  <= 4'd1;
              shreg <= 8'h01;
              st    <= FR_BITS;
            end
          end else if (cnt == MAX_CNT) begin
            err <= 1'b1;
            st  <= FR_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        FR_START: begin
          if (tmr == '0) begin
            if (rx_s) begin
              err <= 1'b1;
              st  <= FR_IDLE;
            end else begin
              bitn  <= 4'd0;
              shreg <= 8'h00;
              tmr   <= bit_t - TMR_W'(1);
              st    <= FR_BITS;
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        FR_BITS: begin
          if (tmr == '0) begin
            if (bitn[3]) begin
              if (rx_s) byte_vld <= 1'b1;
              else      err      <= 1'b1;
              st <= FR_IDLE;
            end else begin
              shreg[bitn[2:0]] <= rx_s;
              bitn             <= bitn + 4'd1;
              tmr              <= bit_t - TMR_W'(1);
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/autobaud_resp.sv
module autobaud_resp
  import autobaud_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sel_cmd,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       done
);
  logic [3:0] idx;
  logic       sel;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      idx      <= '0;
      sel      <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (start) begin
      sel      <= sel_cmd;
      idx      <= '0;
      tx_valid <= 1'b1;
      tx_data  <= reply_byte(sel_cmd, 4'd0);
    end else if (tx_valid && tx_ready) begin
      if (idx == reply_last(sel)) begin
        tx_valid <= 1'b0;
        done     <= 1'b1;
      end else begin
        idx     <= idx + 4'd1;
        tx_data <= reply_byte(sel, idx + 4'd1);
      end
    end
  end
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import autobaud_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int DEFAULT_DIV = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cts_strap_n,
  input  logic             rx,
  output logic [DIV_W-1:0] div_out,
  output logic             div_valid,
  output logic             locked,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready
);
  ctl_e             st;
  logic             armed;
  logic [1:0]       cmd_idx;
  logic             resp_go, resp_sel, resp_done;
  logic             rx_s, rx_fall;
  logic [DIV_W-1:0] fr_div;
  logic             fr_vld, fr_err;
  logic [7:0]       fr_byte;
  logic             fr_en, fr_meas;

  assign fr_en   = (st == CT_FIRST) || (st == CT_MORE);
  assign fr_meas = (st == CT_FIRST);

  always_ff @(posedge clk) begin
    if (rst) armed <= ~cts_strap_n;
  end

  autobaud_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx), .dout(rx_s), .fall(rx_fall)
  );

  autobaud_frame #(.DIV_W(DIV_W)) u_frame (
    .clk(clk), .rst(rst), .en(fr_en), .measure(fr_meas), .fall(rx_fall),
    .rx_s(rx_s), .div_q(fr_div), .byte_vld(fr_vld), .byte_val(fr_byte),
    .err(fr_err)
  );

  autobaud_resp u_resp (
    .clk(clk), .rst(rst), .start(resp_go), .sel_cmd(resp_sel),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .done(resp_done)
  );

  always_ff @(posedge clk) begin
    div_valid <= 1'b0;
    resp_go   <= 1'b0;
    if (rst) begin
      st       <= CT_BOOT;
      locked   <= 1'b0;
      div_out  <= DIV_W'(DEFAULT_DIV);
      cmd_idx  <= '0;
      resp_sel <= 1'b0;
    end else begin
      case (st)
        CT_BOOT: st <= armed ? CT_FIRST : CT_OFF;
        CT_OFF:  st <= CT_OFF;
        CT_FIRST: if (fr_vld) begin
          if (fr_byte == TRAIN_CHAR) begin
            locked    <= 1'b1;
            div_valid <= 1'b1;
            div_out   <= fr_div;
            resp_go   <= 1'b1;
            resp_sel  <= 1'b0;
            st        <= CT_RESP;
          end else if (fr_byte == cmd_byte(2'd0)) begin
            cmd_idx <= 2'd1;
            st      <= CT_MORE;
          end
        end
        CT_MORE: begin
          if (fr_err) begin
            st <= CT_FIRST;
          end else if (fr_vld) begin
            if (fr_byte != cmd_byte(cmd_idx)) begin
              st <= CT_FIRST;
            end else if (cmd_idx == 2'd3) begin
              locked    <= 1'b1;
              div_valid <= 1'b1;
              div_out   <= fr_div;
              resp_go   <= 1'b1;
              resp_sel  <= 1'b1;
              st        <= CT_RESP;
            end else begin
              cmd_idx <= cmd_idx + 2'd1;
            end
          end
        end
        CT_RESP: if (resp_done) st <= CT_DONE;
        CT_DONE: st <= CT_DONE;
        default: st <= CT_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/autobaud_detect_chk.sv
module autobaud_detect_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             armed,
  input logic             locked,
  input logic             div_valid,
  input logic [DIV_W-1:0] div_out,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data
);
  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !locked && !tx_valid); // R1

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R5

  AST_STROBE_AT_LOCK: assert property (@(posedge clk) disable iff (rst)
    div_valid |-> locked && !$past(locked)); // R5

  AST_TX_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> locked); // R5

  AST_DIV_MIN: assert property (@(posedge clk) disable iff (rst)
    locked |-> div_out != '0); // R6

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R9
endmodule

bind autobaud_detect autobaud_detect_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .armed(armed), .locked(locked),
  .div_valid(div_valid), .div_out(div_out), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/autobaud_detect_test.sv
module autobaud_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 12;
  localparam int DEF_DIV    = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cts_strap_n = 1'b1;
  logic             rx = 1'b1;
  logic [DIV_W-1:0] div_out;
  logic             div_valid, locked, tx_valid;
  logic [7:0]       tx_data;
  logic             tx_ready = 1'b1;

  int         checks = 0, fails = 0, cyc = 0, div_pulses = 0;
  int         div_seen = 0;
  bit         stall_mode = 0;
  logic [7:0] exp_q[$];

  autobaud_detect uut (
    .clk(clk), .rst(rst), .cts_strap_n(cts_strap_n), .rx(rx),
    .div_out(div_out), .div_valid(div_valid), .locked(locked),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model of the transmit port, evaluated every clock
  initial begin
    bit         hold = 0;
    logic [7:0] held = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (div_valid) begin
        div_pulses++;
        div_seen = int'(div_out);
      end
      if (hold)
        check(tx_valid === 1'b1 && tx_data === held, "R9", "stalled byte changed",
              {tx_valid, tx_data}, {1'b1, held});
      tx_ready = stall_mode ? ((cyc % 5) < 2) : 1'b1;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected byte", tx_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(tx_data === e, "R3/R4", "acknowledgement byte", tx_data, e);
        end
      end
      hold = tx_valid && !tx_ready;
      held = tx_data;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "all", "watchdog expired", cyc, 200000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic do_reset(input logic strap);
    rst = 1'b1;
    cts_strap_n = strap;
    rx = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cts_strap_n = 1'b1;
    exp_q.delete();
    div_pulses = 0;
    div_seen = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int bitlen);
    rx = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bitlen) @(negedge clk);
    end
    rx = 1'b1;
    repeat (2 * bitlen) @(negedge clk);
  endtask

  task automatic push_char_reply();
    exp_q.push_back(8'h41); exp_q.push_back(8'h30);
    exp_q.push_back(8'h34); exp_q.push_back(8'h31);
  endtask

  task automatic push_cmd_reply();
    exp_q.push_back(8'h04); exp_q.push_back(8'h0E); exp_q.push_back(8'h04);
    exp_q.push_back(8'h01); exp_q.push_back(8'h03); exp_q.push_back(8'h0C);
    exp_q.push_back(8'h00); exp_q.push_back(8'h34); exp_q.push_back(8'h31);
  endtask

  task automatic send_cmd(input logic [7:0] last, input int bitlen);
    send_byte(8'h01, bitlen);
    send_byte(8'h03, bitlen);
    send_byte(8'h0C, bitlen);
    send_byte(last, bitlen);
  endtask

  task automatic expect_lock(input string req, input int exp_div);
    repeat (200) @(negedge clk);
    check(locked === 1'b1, req, "locked", locked, 1);
    check(div_pulses == 1, "R5", "divisor strobe count", div_pulses, 1);
    check(div_seen == exp_div, req, "divisor at strobe", div_seen, exp_div);
    check(div_out == DIV_W'(exp_div), req, "div_out after lock", div_out, exp_div);
    check(exp_q.size() == 0, req, "bytes left unsent", exp_q.size(), 0);
  endtask

  task automatic expect_no_lock(input string req);
    repeat (50) @(negedge clk);
    check(locked === 1'b0 && div_pulses == 0, req, "no lock",
          {locked, div_pulses[7:0]}, 0);
    check(div_out == DIV_W'(DEF_DIV), req, "default divisor kept", div_out, DEF_DIV);
    check(tx_valid === 1'b0, req, "no transmit", tx_valid, 0);
  endtask

  initial begin
    // R1: strap high during reset -> inert
    rst = 1'b1;
    cts_strap_n = 1'b1;
    repeat (3) @(negedge clk);
    check(locked === 1'b0 && tx_valid === 1'b0 && div_valid === 1'b0, "R1",
          "reset outputs", {locked, tx_valid, div_valid}, 0);
    check(div_out == DIV_W'(DEF_DIV), "R1", "reset divisor", div_out, DEF_DIV);
    do_reset(1'b1);
    cts_strap_n = 1'b0;              // low after reset must not arm
    send_byte(8'h41, 160);
    expect_no_lock("R1");
    cts_strap_n = 1'b1;

    // R2 R3 R6: character at 160 clocks -> divisor 10
    do_reset(1'b0);
    push_char_reply();
    send_byte(8'h41, 160);
    expect_lock("R3", 10);

    // R4 R9: command at 200 clocks -> 13, with back-pressure
    do_reset(1'b0);
    stall_mode = 1;
    push_cmd_reply();
    send_cmd(8'h00, 200);
    expect_lock("R4", 13);
    stall_mode = 0;

    // R6 rounding: 168 -> 11, 167 -> 10, minimum 16 -> 1
    do_reset(1'b0);
    push_char_reply();
    send_byte(8'h41, 168);
    expect_lock("R6", 11);
    do_reset(1'b0);
    push_char_reply();
    send_byte(8'h41, 167);
    expect_lock("R6", 10);
    do_reset(1'b0);
    stall_mode = 1;
    push_char_reply();
    send_byte(8'h41, 16);
    expect_lock("R6", 1);
    stall_mode = 0;

    // R7: every low run is 10 clocks, below the limit
    do_reset(1'b0);
    send_byte(8'h55, 10);
    expect_no_lock("R7");
    push_char_reply();
    send_byte(8'h41, 64);
    expect_lock("R2", 4);

    // R8: wrong final command byte, then a good character
    do_reset(1'b0);
    send_cmd(8'h05, 160);
    expect_no_lock("R8");
    push_char_reply();
    send_byte(8'h41, 160);
    expect_lock("R8", 10);

    // R8: foreign first byte
    do_reset(1'b0);
    send_byte(8'h43, 160);
    expect_no_lock("R8");
    push_char_reply();
    send_byte(8'h41, 96);
    expect_lock("R8", 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule